// File: doc/BRIEF.md
# Fractional Timer Prescaler Counter

This block produces the running value of a free-running 64-bit timebase. Each cycle it may receive a one-cycle tick from one of two sources. One is a crystal reference and the other is an alternate clock domain already reduced to ticks. A phase accumulator scales the selected tick stream by a programmable ratio and emits increment pulses. Each pulse advances the counter by one or by two.

Software programs the block over a simple 32-bit register bus. A control word holds the source select and the step size, and a ratio word holds the prescaler value. The output rate is the input tick rate times the ratio divided by 2^31. A ratio of 0x80000000 therefore passes every tick through. Written values sit in shadow registers and are copied into the working configuration on the next tick of the currently selected source.

Top module: `frac_timebase`

## Requirements
- R1: After reset the counter is 0, the control word reads 0 and the ratio word reads 0x80000000.
- R2: A read at offset 0x00 (control) or 0x08 (ratio) returns the last full 32-bit value written there. Reads at any other offset return 0, and writes to other offsets change nothing.
- R3: While control bit 8 is 0 in the working configuration, only `tick_xtal` advances the timebase and `tick_alt` has no effect.
- R4: While control bit 8 is 1 in the working configuration, only `tick_alt` advances the timebase and `tick_xtal` has no effect.
- R5: With ratio 0x80000000, every selected tick produces exactly one increment.
- R6: With a ratio P below 0x80000000 and an empty accumulator, the number of increments after N selected ticks is floor(N*P/2^31). The remainder is carried between ticks.
- R7: With control bit 9 equal to 0 each increment adds 1 to the counter, and with bit 9 equal to 1 each increment adds 2.
- R8: A ratio above 0x80000000 acts as 0x80000000, giving exactly one increment per selected tick. The register still reads back the written value.
- R9: A register write does not alter the working configuration until the next selected tick. That tick is still processed with the previous configuration, and later ticks use the new one.
- R10: With ratio 0 the counter never advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_xtal | input | 1 | One-cycle tick from the crystal reference |
| tick_alt | input | 1 | One-cycle tick from the alternate source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| count_o | output | 64 | Running timebase value |

## Verification
The bench sets the ratio to half and to three quarters, then counts increments tick by tick. A design that loses the accumulator remainder, or that resets it on every pulse, falls behind the floor(N*P/2^31) totals. An all-ones ratio tests the clamp: without it the count would jump or wrap. Other tests cover the tick after a write, which must still use the old setting, and the tick from the source that is not selected. A design that applies writes at once, or that listens to both sources, would show counts that are off by one or by several ticks. A test with a step of two and a test with a ratio of zero show a wrong increment size and any leak of pulses.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned CNT_W   = 64;
    localparam int unsigned ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RATIO = 8'h08;

    localparam int unsigned BIT_SRC  = 8;
    localparam int unsigned BIT_STEP = 9;

    localparam logic [REG_W-1:0] RATIO_UNITY = {1'b1, {(REG_W-1){1'b0}}};

    typedef enum logic { SRC_XTAL = 1'b0, SRC_ALT = 1'b1 } src_e;

    typedef struct packed {
        src_e             src;
        logic             step_two;
        logic [REG_W-1:0] ratio;
    } cfg_t;

    function automatic logic [REG_W-1:0] clamp_ratio(input logic [REG_W-1:0] r);
        return (r > RATIO_UNITY) ? RATIO_UNITY : r;
    endfunction

endpackage

// File: rtl/ftb_regs.sv
module ftb_regs
    import ftb_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          load,
    output cfg_t          cfg_o
);
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] ratio_q;
    cfg_t          work_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ratio_q <= RATIO_UNITY;
        end else if (bus_we) begin
            if (bus_addr == OFS_CTRL)  ctrl_q  <= bus_wdata;
            if (bus_addr == OFS_RATIO) ratio_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '{src: SRC_XTAL, step_two: 1'b0, ratio: RATIO_UNITY};
        end else if (load) begin
            work_q.src      <= src_e'(ctrl_q[BIT_SRC]);
            work_q.step_two <= ctrl_q[BIT_STEP];
            work_q.ratio    <= ratio_q;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL:  bus_rdata = ctrl_q;
            OFS_RATIO: bus_rdata = ratio_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign cfg_o = work_q;

    // R1
    reset_vals_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == '0 && ratio_q == RATIO_UNITY));

    // R9
    hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(load) && !$past(rst) |-> $stable(work_q));

endmodule

// File: rtl/ftb_phase_acc.sv
module ftb_phase_acc
    import ftb_pkg::*;
#(
    parameter int unsigned AW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [AW-1:0] ratio,
    output logic          pulse
);
    localparam logic [AW-1:0] HALF = {1'b1, {(AW-1){1'b0}}};

    logic [AW-1:0] acc_q;
    logic [AW-1:0] inc;
    logic [AW-1:0] sum;
    logic          carry;

    always_comb begin
        inc   = clamp_ratio(ratio);
        sum   = acc_q + inc;
        carry = (sum >= HALF);
        pulse = tick & carry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= carry ? (sum - HALF) : sum;
        end
    end

    // R6
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc_q < HALF);

    // R8
    clamp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ratio >= HALF) |-> pulse);

    // R10
    zero_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio == '0) |-> !pulse);

endmodule

// File: rtl/ftb_counter.sv
module ftb_counter #(
    parameter int unsigned CW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse,
    input  logic          step_two,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] count_q;
    logic [CW-1:0] step;

    assign step = step_two ? CW'(2) : CW'(1);

    always_ff @(posedge clk) begin
        if (rst)        count_q <= '0;
        else if (pulse) count_q <= count_q + step;
    end

    assign count_o = count_q;

    // R7
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> (count_q - $past(count_q)) == ($past(step_two) ? CW'(2) : CW'(1)));

endmodule

// File: rtl/frac_timebase.sv
module frac_timebase
    import ftb_pkg::*;
#(
    parameter int unsigned ADDR_BITS = ADDR_W,
    parameter int unsigned DATA_BITS = REG_W,
    parameter int unsigned COUNT_BITS = CNT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_xtal,
    input  logic                  tick_alt,
    input  logic                  bus_we,
    input  logic [ADDR_BITS-1:0]  bus_addr,
    input  logic [DATA_BITS-1:0]  bus_wdata,
    output logic [DATA_BITS-1:0]  bus_rdata,
    output logic [COUNT_BITS-1:0] count_o
);
    cfg_t cfg;
    logic tick_sel;
    logic pulse;

    assign tick_sel = (cfg.src == SRC_ALT) ? tick_alt : tick_xtal;

    ftb_regs #(.AW(ADDR_BITS), .DW(DATA_BITS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .load      (tick_sel),
        .cfg_o     (cfg)
    );

    ftb_phase_acc #(.AW(DATA_BITS)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_sel),
        .ratio (cfg.ratio),
        .pulse (pulse)
    );

    ftb_counter #(.CW(COUNT_BITS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .pulse    (pulse),
        .step_two (cfg.step_two),
        .count_o  (count_o)
    );

    // R3
    xtal_only_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_XTAL && !tick_xtal) |=> $stable(count_o));

    // R4
    alt_only_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_ALT && !tick_alt) |=> $stable(count_o));

endmodule

// File: tb/frac_timebase_tb.sv
module frac_timebase_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_xtal = 1'b0;
    logic        tick_alt = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    frac_timebase u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_xtal (tick_xtal),
        .tick_alt  (tick_alt),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_o   (count_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic xt(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_xtal = 1'b1;
            @(negedge clk); tick_xtal = 1'b0;
        end
    endtask

    task automatic at(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_alt = 1'b1;
            @(negedge clk); tick_alt = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 count", count_o, 64'd0);
        rd(8'h00, d); chk("R1 ctrl", {32'd0, d}, 64'd0);
        rd(8'h08, d); chk("R1 ratio", {32'd0, d}, 64'h8000_0000);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_reset();
        wr(8'h00, 32'h0000_0A5C);
        wr(8'h08, 32'h1234_5678);
        wr(8'h04, 32'hDEAD_BEEF);
        rd(8'h00, d); chk("R2 ctrl readback", {32'd0, d}, 64'h0000_0A5C);
        rd(8'h08, d); chk("R2 ratio readback", {32'd0, d}, 64'h1234_5678);
        rd(8'h04, d); chk("R2 unmapped read", {32'd0, d}, 64'd0);
    endtask

    task automatic t_unity();
        do_reset();
        xt(5);
        chk("R5 unity five ticks", count_o, 64'd5);
    endtask

    task automatic t_source();
        do_reset();
        at(3);
        chk("R3 alt ignored", count_o, 64'd0);
        wr(8'h00, 32'h0000_0100);
        xt(1);
        chk("R9 switch tick uses xtal", count_o, 64'd1);
        at(4);
        chk("R4 alt counts", count_o, 64'd5);
        xt(3);
        chk("R4 xtal ignored", count_o, 64'd5);
    endtask

    task automatic t_frac();
        do_reset();
        wr(8'h08, 32'h4000_0000);
        xt(1);
        chk("R9 prime old ratio", count_o, 64'd1);
        xt(1);
        chk("R6 half one tick", count_o, 64'd1);
        xt(1);
        chk("R6 half two ticks", count_o, 64'd2);
        xt(4);
        chk("R6 half six ticks", count_o, 64'd4);
        do_reset();
        wr(8'h08, 32'h6000_0000);
        xt(2);
        chk("R6 three-quarter first", count_o, 64'd1);
        xt(3);
        chk("R6 three-quarter four", count_o, 64'd4);
    endtask

    task automatic t_step2();
        do_reset();
        wr(8'h00, 32'h0000_0200);
        xt(1);
        chk("R9 prime old step", count_o, 64'd1);
        xt(3);
        chk("R7 step two", count_o, 64'd7);
    endtask

    task automatic t_clamp();
        logic [31:0] d;
        do_reset();
        wr(8'h08, 32'hFFFF_FFFF);
        xt(1);
        xt(6);
        chk("R8 clamp one per tick", count_o, 64'd7);
        rd(8'h08, d); chk("R8 ratio unclamped readback", {32'd0, d}, 64'hFFFF_FFFF);
    endtask

    task automatic t_zero();
        do_reset();
        wr(8'h08, 32'h0000_0000);
        xt(1);
        chk("R9 prime before zero", count_o, 64'd1);
        xt(5);
        chk("R10 zero ratio frozen", count_o, 64'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_unity();
        t_source();
        t_frac();
        t_step2();
        t_clamp();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule